// File: doc/BRIEF.md
# Interrupt Controller Countdown Timer

This block is the programmable countdown timer that sits beside a local interrupt controller. Software programs three registers over a simple strobe bus: a timer control entry (vector, mask, periodic/one-shot select), an initial count, and a divide configuration. The timer counts base-clock cycles through a power-of-two prescaler. Each divided tick steps a down-counter. When the counter expires, the block emits a one-cycle request that carries the programmed vector, unless the entry is masked.

In one-shot mode the count runs down to zero once and then holds there. In periodic mode the count reloads from the initial value, so each period lasts the initial count plus one divided ticks. The live count can be read back at any time. The prioritizer that accepts the request lies outside this block.

Top module: `ictl_countdown_timer`

## Requirements
- R1: After reset the control entry reads 0x0001_0000 (mask set, one-shot, vector 0). The initial count, current count and divide configuration all read 0, and irq_valid is low.
- R2: A divide write keeps only data bits 3, 1 and 0. The readback shows those bits and all others read as 0. The code is {bit3, bit1, bit0}, the shift is (code+1) mod 8, and a divided tick occurs once every 2^shift clocks. Code 7 (write 0xB) therefore divides by 1, and code 0 (the reset value) divides by 2.
- R3: A write to the initial count loads the current count with the written value and restarts the prescaler. The first decrement lands 2^shift clocks after the write edge.
- R4: In one-shot mode (entry bit 17 = 0) the count decrements once per divided tick. Exactly one expiry fires, on the tick that takes the count from 1 to 0. The count then holds at 0 with no further expiry. A one-shot load of 0 never expires.
- R5: In periodic mode (entry bit 17 = 1) a divided tick with the count at 0 reloads the initial count and fires an expiry. A load of N therefore gives expiries every (N+1)·2^shift clocks.
- R6: A periodic timer whose initial count is 0 never expires.
- R7: While entry bit 16 (mask) is set, no request is raised, but counting continues. A later write that clears the mask lets the following expiries raise requests.
- R8: A request is a single-cycle irq_valid pulse. It appears in the cycle after the expiring edge, with irq_vector equal to entry bits 7:0 and irq_edge high.
- R9: The select encoding is: 0 = control entry, 1 = initial count, 2 = current count (read only; writes are ignored), 3 = divide configuration. rd_data follows rd_sel combinationally.
- R10: A write to the divide configuration restarts the prescaler, so the next tick comes a full 2^shift clocks after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_sel | input | 2 | Register select for the write |
| wr_data | input | DATA_W | Write data |
| rd_sel | input | 2 | Register select for the read |
| rd_data | output | DATA_W | Read data (combinational) |
| irq_valid | output | 1 | Expiry request pulse |
| irq_vector | output | 8 | Vector carried with the request |
| irq_edge | output | 1 | Edge-trigger indication, high with the request |

## Verification
The clock edge that registers a write counts as edge 0. The current count changes at the first divided tick, on edge 2^shift. A one-shot request is visible in the cycle after edge N·2^shift, and periodic requests are visible after every (N+1)·2^shift edges. The bench counts falling edges from the write and samples outputs at the falling edge, so each pulse is checked at its exact cycle offset: it must be present at that count and absent at the count before. Readback values are compared at the same offsets.

// File: rtl/ictl_tmr_pkg.sv
package ictl_tmr_pkg;

    typedef enum logic [1:0] {
        SEL_ENTRY = 2'd0,
        SEL_INIT  = 2'd1,
        SEL_CUR   = 2'd2,
        SEL_DIV   = 2'd3
    } sel_e;

    typedef struct packed {
        logic       periodic;
        logic       mask;
        logic [7:0] vector;
    } entry_t;

    localparam int PER_BIT  = 17;
    localparam int MASK_BIT = 16;
    localparam int SHIFT_W  = 3;
    localparam int PRE_W    = (1 << SHIFT_W) - 1;

    localparam entry_t ENTRY_RST = '{periodic: 1'b0, mask: 1'b1, vector: 8'h00};

    // Kept divide bits {3,1,0} form the code; shift wraps modulo 8.
    function automatic logic [SHIFT_W-1:0] div_shift(input logic [3:0] cfg);
        logic [SHIFT_W-1:0] code;
        code = {cfg[3], cfg[1], cfg[0]};
        return code + SHIFT_W'(1);
    endfunction

    function automatic logic [31:0] pack_entry(input entry_t e);
        logic [31:0] w;
        w = '0;
        w[PER_BIT]  = e.periodic;
        w[MASK_BIT] = e.mask;
        w[7:0]      = e.vector;
        return w;
    endfunction

endpackage

// File: rtl/ictl_tmr_regs.sv
module ictl_tmr_regs
    import ictl_tmr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  sel_e              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output entry_t            entry,
    output logic [DATA_W-1:0] init_cnt,
    output logic [3:0]        div_cfg,
    output logic              init_load,
    output logic              pre_clr
);

    assign init_load = wr_en && (wr_sel == SEL_INIT);
    assign pre_clr   = wr_en && ((wr_sel == SEL_INIT) || (wr_sel == SEL_DIV));

    always_ff @(posedge clk) begin
        if (rst) begin
            entry    <= ENTRY_RST;
            init_cnt <= '0;
            div_cfg  <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_ENTRY: begin
                    entry.periodic <= wr_data[PER_BIT];
                    entry.mask     <= wr_data[MASK_BIT];
                    entry.vector   <= wr_data[7:0];
                end
                SEL_INIT: init_cnt <= wr_data;
                SEL_DIV:  div_cfg  <= {wr_data[3], 1'b0, wr_data[1:0]};
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/ictl_tmr_prescale.sv
module ictl_tmr_prescale
    import ictl_tmr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic [SHIFT_W-1:0] shift,
    output logic               tick
);

    localparam logic [PRE_W-1:0] ONE = PRE_W'(1);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] limit;

    assign limit = (ONE << shift) - ONE;
    assign tick  = !clr && (pre_q == limit);

    always_ff @(posedge clk) begin
        if (rst || clr || tick) pre_q <= '0;
        else                    pre_q <= pre_q + ONE;
    end

endmodule

// File: rtl/ictl_tmr_core.sv
module ictl_tmr_core
    import ictl_tmr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              tick,
    input  entry_t            entry,
    input  logic [DATA_W-1:0] init_cnt,
    output logic [DATA_W-1:0] cur,
    output logic              irq_valid,
    output logic [7:0]        irq_vector
);

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    logic expire;
    logic [DATA_W-1:0] cur_nxt;

    always_comb begin
        expire  = 1'b0;
        cur_nxt = cur;
        if (load) begin
            cur_nxt = load_val;
        end else if (tick) begin
            if (entry.periodic) begin
                if (cur == '0) begin
                    if (init_cnt != '0) begin
                        cur_nxt = init_cnt;
                        expire  = 1'b1;
                    end
                end else begin
                    cur_nxt = cur - ONE;
                end
            end else if (cur != '0) begin
                cur_nxt = cur - ONE;
                expire  = (cur == ONE);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur        <= '0;
            irq_valid  <= 1'b0;
            irq_vector <= '0;
        end else begin
            cur       <= cur_nxt;
            irq_valid <= expire && !entry.mask;
            if (expire) irq_vector <= entry.vector;
        end
    end

endmodule

// File: rtl/ictl_countdown_timer.sv
module ictl_countdown_timer
    import ictl_tmr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_valid,
    output logic [7:0]        irq_vector,
    output logic              irq_edge
);

    entry_t            entry;
    logic [DATA_W-1:0] init_cnt;
    logic [DATA_W-1:0] cur;
    logic [3:0]        div_cfg;
    logic              init_load;
    logic              pre_clr;
    logic              tick;
    logic [31:0]       entry_word;

    ictl_tmr_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_sel    (sel_e'(wr_sel)),
        .wr_data   (wr_data),
        .entry     (entry),
        .init_cnt  (init_cnt),
        .div_cfg   (div_cfg),
        .init_load (init_load),
        .pre_clr   (pre_clr)
    );

    ictl_tmr_prescale u_pre (
        .clk   (clk),
        .rst   (rst),
        .clr   (pre_clr),
        .shift (div_shift(div_cfg)),
        .tick  (tick)
    );

    ictl_tmr_core #(.DATA_W(DATA_W)) u_core (
        .clk        (clk),
        .rst        (rst),
        .load       (init_load),
        .load_val   (wr_data),
        .tick       (tick),
        .entry      (entry),
        .init_cnt   (init_cnt),
        .cur        (cur),
        .irq_valid  (irq_valid),
        .irq_vector (irq_vector)
    );

    assign entry_word = pack_entry(entry);
    assign irq_edge   = irq_valid;

    always_comb begin
        case (sel_e'(rd_sel))
            SEL_ENTRY: rd_data = DATA_W'(entry_word);
            SEL_INIT:  rd_data = init_cnt;
            SEL_CUR:   rd_data = cur;
            SEL_DIV:   rd_data = DATA_W'(div_cfg);
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/ictl_tmr_chk.sv
module ictl_tmr_chk
    import ictl_tmr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              irq_valid,
    input logic [7:0]        irq_vector,
    input logic              irq_edge,
    input entry_t            entry,
    input logic [DATA_W-1:0] cur,
    input logic [DATA_W-1:0] init_cnt,
    input logic [3:0]        div_cfg,
    input logic              init_load
);

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (entry.mask && init_cnt == '0 && cur == '0 && div_cfg == '0 && !irq_valid)); // R1

    AST_MASK_SILENT: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> !$past(entry.mask)); // R7

    AST_VECTOR_MATCH: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> (irq_vector == $past(entry.vector) && irq_edge)); // R8

    AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cur == '0 && !entry.periodic && !init_load) |=> (cur == '0 && !irq_valid)); // R4

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (cur != '0 && !init_load) |=> (cur == $past(cur) || cur == $past(cur) - DATA_W'(1))); // R4

    AST_ZERO_PERIOD: assert property (@(posedge clk) disable iff (rst)
        (entry.periodic && init_cnt == '0 && cur == '0 && !init_load) |=> !irq_valid); // R6

    AST_DIV_BITS: assert property (@(posedge clk) disable iff (rst)
        div_cfg[2] == 1'b0); // R2

endmodule

bind ictl_countdown_timer ictl_tmr_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .irq_valid  (irq_valid),
    .irq_vector (irq_vector),
    .irq_edge   (irq_edge),
    .entry      (entry),
    .cur        (cur),
    .init_cnt   (init_cnt),
    .div_cfg    (div_cfg),
    .init_load  (init_load)
);

// File: tb/tb_ictl_countdown_timer.sv
module tb_ictl_countdown_timer;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam logic [1:0] S_ENT = 2'd0, S_INIT = 2'd1, S_CUR = 2'd2, S_DIV = 2'd3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = '0;
    logic [DW-1:0] wr_data = '0;
    logic [1:0]    rd_sel = '0;
    logic [DW-1:0] rd_data;
    logic          irq_valid;
    logic [7:0]    irq_vector;
    logic          irq_edge;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ictl_countdown_timer #(.DATA_W(DW)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .irq_valid(irq_valid),
        .irq_vector(irq_vector), .irq_edge(irq_edge)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            failures = failures + 1;
            $display("FAIL watchdog expired at cycle %0d", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [DW-1:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [DW-1:0] d);
        rd_sel = s;
        #1;
        d = rd_data;
    endtask

    task automatic wait_irq(input int max, output int found);
        found = -1;
        for (int k = 0; k <= max; k++) begin
            if (irq_valid) begin
                found = k;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic quiet();
        wr(S_ENT, 32'h0001_0000);
        wr(S_INIT, 32'd0);
    endtask

    task automatic t_reset();
        logic [DW-1:0] v;
        rd(S_ENT, v);  check(v == 32'h0001_0000, "R1 entry", v, 32'h0001_0000);
        rd(S_INIT, v); check(v == 0, "R1 init", v, 0);
        rd(S_CUR, v);  check(v == 0, "R1 cur", v, 0);
        rd(S_DIV, v);  check(v == 0, "R1 div", v, 0);
        check(!irq_valid, "R1 irq", irq_valid, 0);
    endtask

    task automatic t_div_bits();
        logic [DW-1:0] v;
        wr(S_DIV, 32'hFFFF_FFFF);
        rd(S_DIV, v); check(v == 32'hB, "R2 div readback", v, 32'hB);
    endtask

    task automatic t_oneshot();
        int f;
        logic [DW-1:0] v;
        quiet();
        wr(S_DIV, 32'hB);
        wr(S_ENT, 32'h0000_0041);
        wr(S_INIT, 32'd5);
        wait_irq(40, f);
        check(f == 5, "R4 one-shot expiry cycle", f, 5);
        check(irq_vector == 8'h41, "R8 vector", irq_vector, 8'h41);
        check(irq_edge == 1'b1, "R8 edge flag", irq_edge, 1);
        @(negedge clk);
        check(!irq_valid, "R8 single-cycle pulse", irq_valid, 0);
        wait_irq(30, f);
        check(f == -1, "R4 no second expiry", f, -1);
        rd(S_CUR, v); check(v == 0, "R4 holds at zero", v, 0);
        wr(S_INIT, 32'd0);
        wait_irq(20, f);
        check(f == -1, "R4 one-shot zero load silent", f, -1);
    endtask

    task automatic t_divider(input logic [DW-1:0] cfg, input int n, input int expk, input string tag);
        int f;
        quiet();
        wr(S_DIV, cfg);
        wr(S_ENT, 32'h0000_0022);
        wr(S_INIT, DW'(n));
        wait_irq(expk + 20, f);
        check(f == expk, tag, f, expk);
    endtask

    task automatic t_start();
        logic [DW-1:0] v;
        quiet();
        wr(S_DIV, 32'h0);
        wr(S_ENT, 32'h0001_0000);
        wr(S_INIT, 32'd5);
        rd(S_CUR, v); check(v == 5, "R3 loaded", v, 5);
        @(negedge clk);
        rd(S_CUR, v); check(v == 5, "R3 no tick before 2 clocks", v, 5);
        @(negedge clk);
        rd(S_CUR, v); check(v == 4, "R3 first tick", v, 4);
        @(negedge clk);
        wr(S_INIT, 32'd7);
        @(negedge clk);
        rd(S_CUR, v); check(v == 7, "R3 restart holds", v, 7);
        @(negedge clk);
        rd(S_CUR, v); check(v == 6, "R3 restart tick", v, 6);
    endtask

    task automatic t_periodic();
        int cnt = 0;
        logic [DW-1:0] v;
        quiet();
        wr(S_DIV, 32'hB);
        wr(S_ENT, 32'h0002_0077);
        wr(S_INIT, 32'd3);
        for (int k = 0; k <= 16; k++) begin
            if (irq_valid) begin
                cnt++;
                check(k % 4 == 0 && k > 0, "R5 periodic pulse position", k, 4 * cnt);
                rd(S_CUR, v);
                check(v == 3, "R5 reload value", v, 3);
            end
            @(negedge clk);
        end
        check(cnt == 4, "R5 pulse count", cnt, 4);
    endtask

    task automatic t_zero_period();
        int f;
        quiet();
        wr(S_DIV, 32'hB);
        wr(S_ENT, 32'h0002_0011);
        wr(S_INIT, 32'd0);
        wait_irq(50, f);
        check(f == -1, "R6 zero periodic silent", f, -1);
    endtask

    task automatic t_mask();
        int f;
        bit saw0 = 0, saw2 = 0, any = 0;
        logic [DW-1:0] v;
        quiet();
        wr(S_DIV, 32'hB);
        wr(S_ENT, 32'h0003_0055);
        wr(S_INIT, 32'd2);
        for (int k = 0; k < 30; k++) begin
            if (irq_valid) any = 1;
            rd(S_CUR, v);
            if (v == 0) saw0 = 1;
            if (v == 2) saw2 = 1;
            @(negedge clk);
        end
        check(!any, "R7 masked silent", any, 0);
        check(saw0 && saw2, "R7 counting continues", {saw0, saw2}, 3);
        wr(S_ENT, 32'h0002_0055);
        wait_irq(10, f);
        check(f >= 0, "R7 unmask resumes", f, 0);
        check(irq_vector == 8'h55, "R8 vector after unmask", irq_vector, 8'h55);
    endtask

    task automatic t_cur_ro();
        logic [DW-1:0] v;
        quiet();
        wr(S_DIV, 32'hB);
        wr(S_ENT, 32'h0001_0000);
        wr(S_INIT, 32'd100);
        wr(S_CUR, 32'd5);
        rd(S_CUR, v); check(v == 99, "R9 current count write ignored", v, 99);
        rd(S_INIT, v); check(v == 100, "R9 initial readback", v, 100);
    endtask

    task automatic t_div_restart();
        int f;
        quiet();
        wr(S_DIV, 32'h3);
        wr(S_ENT, 32'h0000_0033);
        wr(S_INIT, 32'd10);
        repeat (10) @(negedge clk);
        wr(S_DIV, 32'h3);
        wait_irq(400, f);
        check(f == 160, "R10 divide write restarts prescaler", f, 160);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_div_bits();
        t_oneshot();
        t_divider(32'h2, 4, 32, "R2 divide by 8");
        t_divider(32'hA, 2, 256, "R2 divide by 128");
        t_divider(32'h0, 3, 6, "R2 reset code divides by 2");
        t_start();
        t_periodic();
        t_zero_period();
        t_mask();
        t_cur_ro();
        t_div_restart();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule